// File: doc/BRIEF.md
# Dual-Mode Watchdog Timer

This block is a 32-bit down-counter behind a small memory-mapped register port. It runs in one of two modes. As an interval timer, it raises an interrupt when the count expires. As a watchdog, the expiry instead produces a one-cycle reset request to the system reset controller and sets a sticky reset flag. A programmable 8-bit prescaler sets the counting rate. The counter can stop at zero or reload itself from the load value.

Software programs the load value, the control word and the clear-on-write-one status flags through single-cycle writes. Reads are combinational from the byte offset. After watchdog mode is turned on, a control write cannot turn it off. The only exit is a write of two fixed key words, one after the other, to a write-only key register.

Top module: `wdt_dual`

## Requirements
- R1: Register byte offsets are load 0x20, counter 0x24, control 0x28, event status 0x2C, reset status 0x30 and key 0x34. After power-on reset every register reads 0. The key register and any unmapped offset read 0.
- R2: Control layout: bit 0 run, bit 1 auto-reload (0 = single-shot), bit 2 interrupt enable, bit 3 watchdog mode, bits 15:8 prescale. Bits 7:4 and 31:16 read 0.
- R3: A write to the load register sets both load and counter. A write to the counter register changes only the counter.
- R4: While run is 1, the counter decrements once every prescale+1 clock cycles. A write to load or counter restarts the prescale count. While run is 0, the counter holds its value.
- R5: The decrement that brings the counter to 0 sets the event flag (status bit 0). In single-shot mode the counter then stays at 0.
- R6: In auto-reload mode, a count step taken at 0 reloads the counter from the load register, so the counter cycles through load+1 values.
- R7: Writing 1 to event status bit 0 clears the event flag. Writing 0 there has no effect.
- R8: In timer mode, `irq` is the event flag ANDed with interrupt enable. In watchdog mode, `irq` is 0.
- R9: In watchdog mode, reaching 0 drives `wd_rst_req` high for exactly one cycle and sets reset status bit 0. That flag is cleared only by power-on reset or by writing 1 to bit 0.
- R10: Once the watchdog mode bit is 1, a control write with bit 3 at 0 leaves it at 1.
- R11: The mode bit clears when the key register receives 0x87654321 as the very next key-register write after 0x12345678. Any other value written to the key register restarts the sequence. A repeated 0x12345678 keeps the sequence armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Timer-mode interrupt |
| wd_rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
The hardest state to reach from the ports is the armed key sequence after watchdog mode has fired. The bench first lets the watchdog expire, and checks the reset pulse and the sticky flag. It then tries a control write to clear the mode bit, which must fail. Next it breaks the key sequence with a wrong word in the middle, and finally sends a valid sequence that starts with a repeated first key. The mode bit is read back after each step.

// File: rtl/wdt_dual.sv
module wdt_dual #(
  parameter logic [31:0] KEY_A = 32'h1234_5678,
  parameter logic [31:0] KEY_B = 32'h8765_4321
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        wd_rst_req
);
  localparam logic [7:0] A_LD  = 8'h20;
  localparam logic [7:0] A_CNT = 8'h24;
  localparam logic [7:0] A_CTL = 8'h28;
  localparam logic [7:0] A_EVT = 8'h2C;
  localparam logic [7:0] A_RST = 8'h30;
  localparam logic [7:0] A_KEY = 8'h34;

  logic [31:0] ld_q, cnt_q;
  logic [7:0]  pre_q, div_q;
  logic        run_q, rel_q, ie_q, wd_q, evt_q, rfl_q, armed_q, req_q;

  wire wr_ld  = bus_we && bus_addr == A_LD;
  wire wr_cnt = bus_we && bus_addr == A_CNT;
  wire wr_ctl = bus_we && bus_addr == A_CTL;
  wire wr_evt = bus_we && bus_addr == A_EVT;
  wire wr_rst = bus_we && bus_addr == A_RST;
  wire wr_key = bus_we && bus_addr == A_KEY;
  wire tick   = run_q && div_q == pre_q;
  wire hit    = tick && cnt_q == 32'd1 && !wr_ld && !wr_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                              div_q <= '0;
    else if (!run_q || tick || wr_ld || wr_cnt) div_q <= '0;
    else                                     div_q <= div_q + 8'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ld_q  <= '0;
      cnt_q <= '0;
    end else if (wr_ld) begin
      ld_q  <= bus_wdata;
      cnt_q <= bus_wdata;
    end else if (wr_cnt) begin
      cnt_q <= bus_wdata;
    end else if (tick) begin
      if (cnt_q != 32'd0) cnt_q <= cnt_q - 32'd1;
      else if (rel_q)     cnt_q <= ld_q;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre_q <= '0; run_q <= 1'b0; rel_q <= 1'b0; ie_q <= 1'b0; wd_q <= 1'b0;
    end else if (wr_ctl) begin
      pre_q <= bus_wdata[15:8];
      ie_q  <= bus_wdata[2];
      rel_q <= bus_wdata[1];
      run_q <= bus_wdata[0];
      wd_q  <= wd_q | bus_wdata[3];
    end else if (wr_key && armed_q && bus_wdata == KEY_B) begin
      wd_q  <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      armed_q <= 1'b0;
    else if (wr_key) armed_q <= (bus_wdata == KEY_A);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                       evt_q <= 1'b0;
    else if (hit)                     evt_q <= 1'b1;
    else if (wr_evt && bus_wdata[0])  evt_q <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                       rfl_q <= 1'b0;
    else if (hit && wd_q)             rfl_q <= 1'b1;
    else if (wr_rst && bus_wdata[0])  rfl_q <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= hit && wd_q;

  assign irq        = evt_q && ie_q && !wd_q;
  assign wd_rst_req = req_q;

  always_comb
    case (bus_addr)
      A_LD:    bus_rdata = ld_q;
      A_CNT:   bus_rdata = cnt_q;
      A_CTL:   bus_rdata = {16'd0, pre_q, 4'd0, wd_q, ie_q, rel_q, run_q};
      A_EVT:   bus_rdata = {31'd0, evt_q};
      A_RST:   bus_rdata = {31'd0, rfl_q};
      default: bus_rdata = '0;
    endcase

  a_r5_zero_sets_event: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q == 32'd1 && !wr_ld && !wr_cnt) |=> evt_q);
  a_r5_single_shot_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !rel_q && cnt_q == 32'd0 && !wr_ld && !wr_cnt) |=> cnt_q == 32'd0);
  a_r9_req_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst_req |-> (rfl_q && wd_q));
  a_r9_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst_req |=> !wd_rst_req);
  a_r9_flag_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rfl_q) |-> $past(wr_rst && bus_wdata[0]));
  a_r10_mode_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_q && wr_ctl) |=> wd_q);
  a_r8_no_irq_in_wd: assert property (@(posedge clk) disable iff (!rst_n)
    wd_q |-> !irq);
endmodule

// File: tb/tb_wdt_dual.sv
module tb_wdt_dual;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, wd_rst_req;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  wdt_dual dut (.clk, .rst_n, .bus_we, .bus_addr, .bus_wdata, .bus_rdata, .irq, .wd_rst_req);

  always #5 clk = ~clk;

  localparam int NV = 14;
  localparam logic [72:0] VEC [NV] = '{
    {1'b0, 8'h20, 32'h0, 32'h0},
    {1'b0, 8'h24, 32'h0, 32'h0},
    {1'b0, 8'h28, 32'h0, 32'h0},
    {1'b0, 8'h2C, 32'h0, 32'h0},
    {1'b0, 8'h30, 32'h0, 32'h0},
    {1'b1, 8'h28, 32'hFFFF_FFF6, 32'h0},
    {1'b0, 8'h28, 32'h0, 32'h0000_FF06},
    {1'b1, 8'h20, 32'h0000_1234, 32'h0},
    {1'b0, 8'h24, 32'h0, 32'h0000_1234},
    {1'b1, 8'h24, 32'h0000_0055, 32'h0},
    {1'b0, 8'h24, 32'h0, 32'h0000_0055},
    {1'b0, 8'h20, 32'h0, 32'h0000_1234},
    {1'b0, 8'h34, 32'h0, 32'h0},
    {1'b0, 8'h00, 32'h0, 32'h0}
  };

  function automatic string vtag(int i);
    if (i < 5 || i > 11) return "R1";
    if (i < 7) return "R2";
    return "R3";
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1;
    d = bus_rdata;
  endtask

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog timeout");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    step(3); rst_n = 1'b1; step(1);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) wr(VEC[i][71:64], VEC[i][63:32]);
      else begin rd(VEC[i][71:64], v); chk(vtag(i), v, VEC[i][31:0]); end
    end

    // R4: disabled counter holds
    wr(8'h28, 32'h0); wr(8'h20, 32'd3); step(5);
    rd(8'h24, v); chk("R4 hold", v, 32'd3);

    // R4/R5: prescale 1, load 3 -> event after 6 cycles
    wr(8'h28, 32'h0000_0105);
    n = 0;
    forever begin
      rd(8'h2C, v);
      if (v[0] || n > 50) break;
      step(1); n++;
    end
    chk("R4 rate", n, 6);
    chk("R8 irq", {31'd0, irq}, 32'd1);
    step(10); rd(8'h24, v); chk("R5 stop", v, 32'd0);
    wr(8'h2C, 32'h0); rd(8'h2C, v); chk("R7 write0", v, 32'd1);
    chk("R8 irq kept", {31'd0, irq}, 32'd1);
    wr(8'h2C, 32'h1); rd(8'h2C, v); chk("R7 clear", v, 32'd0);
    chk("R8 irq clr", {31'd0, irq}, 32'd0);

    // R6: auto-reload, load 2, prescale 0
    wr(8'h28, 32'h0); wr(8'h20, 32'd2); wr(8'h28, 32'h0000_0003);
    step(3); rd(8'h24, v); chk("R6 reload", v, 32'd2);
    rd(8'h2C, v); chk("R6 event", v, 32'd1);
    wr(8'h28, 32'h0); wr(8'h2C, 32'h1);

    // R9: watchdog expiry
    wr(8'h20, 32'd2); wr(8'h28, 32'h0000_000D);
    step(1); chk("R9 no early req", {31'd0, wd_rst_req}, 32'd0);
    step(1); chk("R9 req", {31'd0, wd_rst_req}, 32'd1);
    chk("R8 wd irq", {31'd0, irq}, 32'd0);
    rd(8'h30, v); chk("R9 flag", v, 32'd1);
    step(1); chk("R9 pulse", {31'd0, wd_rst_req}, 32'd0);
    step(5); wr(8'h30, 32'h0); rd(8'h30, v); chk("R9 sticky", v, 32'd1);
    wr(8'h30, 32'h1); rd(8'h30, v); chk("R9 clear", v, 32'd0);

    // R10
    wr(8'h28, 32'h0); rd(8'h28, v); chk("R10 sticky mode", v, 32'h8);

    // R11
    wr(8'h34, 32'h1234_5678); wr(8'h34, 32'hDEAD_BEEF); wr(8'h34, 32'h8765_4321);
    rd(8'h28, v); chk("R11 broken seq", v, 32'h8);
    wr(8'h34, 32'h8765_4321); rd(8'h28, v); chk("R11 no first key", v, 32'h8);
    wr(8'h34, 32'h1234_5678); wr(8'h34, 32'h1234_5678); wr(8'h34, 32'h8765_4321);
    rd(8'h28, v); chk("R11 unlock", v, 32'h0);
    wr(8'h28, 32'h0); rd(8'h28, v); chk("R11 stays off", v, 32'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule